// File: doc/BRIEF.md
# Page-Write Status Flag Generator for a Byte-Wide EEPROM

This block models the status side of a byte-wide parallel EEPROM while page writes run. A host issues byte writes on a parallel address/data bus. The first write opens a page load. Each further byte for the same page restarts a load timer. When the timer runs out, or when a byte names a different page, the loaded bytes go into a fixed-length internal programming cycle. When that cycle ends, the bytes are committed to a small behavioural array.

For the whole busy period, load and programming together, a read returns a status byte on the data lines instead of memory contents. Bit 7 carries the inverse of bit 7 of the last accepted byte, which acts as a polling flag. Bit 6 flips on every read. Bit 5 shows whether the load timer has expired. When the block is idle, a read returns the addressed memory byte. A host polls with reads until the real data comes back.

Top module: `eeprom_wstat`

## Requirements
- R1: After reset the block is idle and every memory byte reads back as 0x00.
- R2: A write while idle is accepted and starts a page load. Any read during the load returns a status byte with bit 5 = 0 and bits 4..0 = 0.
- R3: During the busy period a read at any address returns on bit 7 the inverse of bit 7 of the last accepted byte.
- R4: Bit 6 of the status byte is 0 on the first read of a busy period and flips on each further read in that period, including across the change from load to programming.
- R5: The load timer restarts on each accepted byte. Programming begins LOAD_CYC clock cycles after the last accepted byte. A read at that edge still shows bit 5 = 0, and a read one cycle later shows bit 5 = 1.
- R6: The page is the address bits above the low PAGE_W bits. During a load, a write to a different page is discarded and starts programming at once.
- R7: Programming lasts WRITE_CYC cycles. The last read inside it returns status, and the next read returns memory. A write accepted after that starts a new load.
- R8: Writes issued during programming change neither memory nor the loaded page.
- R9: Once programming ends, each loaded byte reads back at its address, and bytes of the page that were not loaded keep their earlier value.
- R10: A second write to the same address within one load replaces the first, and only the later value is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Byte write strobe, one cycle per byte |
| re_i | input | 1 | Read strobe; rdata_o updates at this edge |
| addr_i | input | ADDR_W | Byte address; upper bits select the page |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Status byte while busy, memory byte while idle |

## Verification
A wrong load or programming counter moves the edge at which bit 5 rises, or the edge at which reads return data instead of status. Directed reads placed exactly on those edges expose the error within one cycle. A corrupted toggle register or last-byte register shows on the very next busy read as a wrong bit 6 or bit 7. A page buffer that accepts stray or out-of-page bytes stays hidden until programming ends, and then shows up on the first read of the affected address.

// File: rtl/eews_pkg.sv
package eews_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } wstate_e;

  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned POLL_BIT = 7;
  localparam int unsigned TGL_BIT  = 6;
  localparam int unsigned TMO_BIT  = 5;
endpackage

// File: rtl/eews_ctrl.sv
module eews_ctrl import eews_pkg::*; #(
  parameter int unsigned LOAD_CYC  = 100,
  parameter int unsigned WRITE_CYC = 1000
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    we_i,
  input  logic    re_i,
  input  logic    same_page_i,
  output wstate_e state_o,
  output logic    accept_o,
  output logic    commit_o,
  output logic    toggle_o
);
  localparam int unsigned LW = $clog2(LOAD_CYC + 1);
  localparam int unsigned WW = $clog2(WRITE_CYC + 1);

  wstate_e state_q, state_d;
  logic [LW-1:0] ld_cnt_q;
  logic [WW-1:0] wr_cnt_q;
  logic          tgl_q;
  logic          ld_expired;

  assign ld_expired = (ld_cnt_q == LW'(LOAD_CYC - 1));
  assign accept_o   = we_i && ((state_q == ST_IDLE) ||
                               (state_q == ST_LOAD && same_page_i));
  assign commit_o   = (state_q == ST_PROG) && (wr_cnt_q == WW'(WRITE_CYC - 1));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (we_i) state_d = ST_LOAD;
      ST_LOAD: begin
        if (we_i && !same_page_i)  state_d = ST_PROG;
        else if (!we_i && ld_expired) state_d = ST_PROG;
      end
      ST_PROG: if (commit_o) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      ld_cnt_q <= '0;
      wr_cnt_q <= '0;
      tgl_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_o)                ld_cnt_q <= '0;
      else if (state_q == ST_LOAD) ld_cnt_q <= ld_cnt_q + 1'b1;
      if (state_q != ST_PROG) wr_cnt_q <= '0;
      else                    wr_cnt_q <= wr_cnt_q + 1'b1;
      // toggle restarts at 0 for every busy period
      if (state_q == ST_IDLE) tgl_q <= 1'b0;
      else if (re_i)          tgl_q <= ~tgl_q;
    end
  end

  assign state_o  = state_q;
  assign toggle_o = tgl_q;

  p_load_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_LOAD |-> ld_cnt_q < LW'(LOAD_CYC));
  p_commit_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> state_q == ST_IDLE);
  p_prog_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PROG && !commit_o) |=> state_q == ST_PROG);
endmodule

// File: rtl/eews_page_buf.sv
module eews_page_buf import eews_pkg::*; #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned PAGE_W = 4
) (
  input  logic                                     clk_i,
  input  logic                                     rst_ni,
  input  logic                                     accept_i,
  input  logic                                     commit_i,
  input  logic                                     prog_i,
  input  logic [ADDR_W-1:0]                        addr_i,
  input  logic [BYTE_W-1:0]                        wdata_i,
  output logic                                     same_page_o,
  output logic [ADDR_W-PAGE_W-1:0]                 page_o,
  output logic [(1<<PAGE_W)-1:0][BYTE_W-1:0]       data_o,
  output logic [(1<<PAGE_W)-1:0]                   valid_o,
  output logic                                     last_b7_o
);
  localparam int unsigned PAGE_BYTES = 1 << PAGE_W;
  localparam int unsigned TAG_W      = ADDR_W - PAGE_W;

  logic [TAG_W-1:0]                  tag_q;
  logic [PAGE_BYTES-1:0][BYTE_W-1:0] data_q;
  logic [PAGE_BYTES-1:0]             valid_q;
  logic                              last_b7_q;
  logic [PAGE_W-1:0]                 off;

  assign off         = addr_i[PAGE_W-1:0];
  assign same_page_o = (addr_i[ADDR_W-1:PAGE_W] == tag_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q     <= '0;
      last_b7_q <= 1'b0;
    end else if (accept_i) begin
      tag_q     <= addr_i[ADDR_W-1:PAGE_W];
      last_b7_q <= wdata_i[BYTE_W-1];
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q[g]  <= '0;
        valid_q[g] <= 1'b0;
      end else if (commit_i) begin
        valid_q[g] <= 1'b0;
      end else if (accept_i && off == PAGE_W'(g)) begin
        data_q[g]  <= wdata_i;
        valid_q[g] <= 1'b1;
      end
    end
  end

  assign page_o    = tag_q;
  assign data_o    = data_q;
  assign valid_o   = valid_q;
  assign last_b7_o = last_b7_q;

  p_buf_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_i && !commit_i) |=> ($stable(data_q) && $stable(valid_q) && $stable(tag_q)));
endmodule

// File: rtl/eews_mem_array.sv
module eews_mem_array import eews_pkg::*; #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned PAGE_W = 4
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               commit_i,
  input  logic [ADDR_W-PAGE_W-1:0]           page_i,
  input  logic [(1<<PAGE_W)-1:0][BYTE_W-1:0] data_i,
  input  logic [(1<<PAGE_W)-1:0]             valid_i,
  input  logic [ADDR_W-1:0]                  raddr_i,
  output logic [BYTE_W-1:0]                  rdata_o
);
  localparam int unsigned PAGE_BYTES = 1 << PAGE_W;
  localparam int unsigned TAG_W      = ADDR_W - PAGE_W;
  localparam int unsigned DEPTH      = 1 << ADDR_W;

  logic [DEPTH-1:0][BYTE_W-1:0] words;

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    localparam int unsigned OFF = w % PAGE_BYTES;
    localparam int unsigned PG  = w / PAGE_BYTES;
    logic [BYTE_W-1:0] cell_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cell_q <= '0;
      else if (commit_i && page_i == TAG_W'(PG) && valid_i[OFF]) cell_q <= data_i[OFF];
    end
    assign words[w] = cell_q;
  end

  assign rdata_o = words[raddr_i];
endmodule

// File: rtl/eeprom_wstat.sv
module eeprom_wstat import eews_pkg::*; #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned PAGE_W    = 4,
  parameter int unsigned LOAD_CYC  = 100,
  parameter int unsigned WRITE_CYC = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);
  localparam int unsigned PAGE_BYTES = 1 << PAGE_W;
  localparam int unsigned TAG_W      = ADDR_W - PAGE_W;

  wstate_e                           state;
  logic                              accept, commit, toggle, same_page, last_b7, busy;
  logic [TAG_W-1:0]                  page;
  logic [PAGE_BYTES-1:0][BYTE_W-1:0] pdata;
  logic [PAGE_BYTES-1:0]             pvalid;
  logic [BYTE_W-1:0]                 mem_rd, status, rdata_q;

  eews_ctrl #(.LOAD_CYC(LOAD_CYC), .WRITE_CYC(WRITE_CYC)) i_ctrl (
    .clk_i, .rst_ni, .we_i, .re_i,
    .same_page_i(same_page), .state_o(state), .accept_o(accept),
    .commit_o(commit), .toggle_o(toggle)
  );

  eews_page_buf #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) i_buf (
    .clk_i, .rst_ni, .accept_i(accept), .commit_i(commit),
    .prog_i(state == ST_PROG), .addr_i, .wdata_i,
    .same_page_o(same_page), .page_o(page), .data_o(pdata),
    .valid_o(pvalid), .last_b7_o(last_b7)
  );

  eews_mem_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) i_mem (
    .clk_i, .rst_ni, .commit_i(commit), .page_i(page), .data_i(pdata),
    .valid_i(pvalid), .raddr_i(addr_i), .rdata_o(mem_rd)
  );

  assign busy = (state != ST_IDLE);

  always_comb begin
    status           = '0;
    status[POLL_BIT] = ~last_b7;
    status[TGL_BIT]  = toggle;
    status[TMO_BIT]  = (state == ST_PROG);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= busy ? status : mem_rd;
  end

  assign rdata_o = rdata_q;

  p_dq5_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && state == ST_LOAD) |=> (rdata_o[TMO_BIT] == 1'b0 && rdata_o[4:0] == '0));
  p_dq7_poll_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && busy) |=> rdata_o[POLL_BIT] == !$past(last_b7));
endmodule

// File: tb/test_eeprom_wstat.sv
module test_eeprom_wstat;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned ADDR_W     = 8;
  localparam int unsigned PAGE_W     = 4;
  localparam int unsigned LOAD_CYC   = 100;
  localparam int unsigned WRITE_CYC  = 1000;
  localparam int unsigned WDOG_CYC   = 50000;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              we_i = 1'b0;
  logic              re_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [7:0]        wdata_i = '0;
  logic [7:0]        rdata_o;

  int n_run = 0;
  int n_fail = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_wstat #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .LOAD_CYC(LOAD_CYC),
                 .WRITE_CYC(WRITE_CYC)) i_eeprom_wstat (
    .clk_i(clk), .rst_ni, .we_i, .re_i, .addr_i, .wdata_i, .rdata_o
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    we_i = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
    re_i = 1'b1; addr_i = a;
    @(negedge clk);
    re_i = 1'b0;
    chk(req, rdata_o, exp);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    rd_chk(8'h00, 8'h00, "R1 reset read");
    rd_chk(8'h35, 8'h00, "R1 reset read");
  endtask

  // status byte: {~last_b7, toggle, timed_out, 5'b0}
  task automatic t_page_load();
    wr(8'h30, 8'hA5);
    wr(8'h31, 8'h3C);
    rd_chk(8'h00, 8'h80, "R2 R3 R4 first status read");
    rd_chk(8'h31, 8'hC0, "R4 toggle flips");
    rd_chk(8'h7F, 8'h80, "R4 toggle flips back");
    wr(8'h3F, 8'h81);
    wait_cyc(LOAD_CYC - 1);
    rd_chk(8'h3F, 8'h40, "R5 timer still running at last load edge");
    rd_chk(8'h3F, 8'h20, "R5 timed out, programming");
    wr(8'h31, 8'hFF);
    wait_cyc(WRITE_CYC - 3);
    rd_chk(8'h3F, 8'h60, "R7 last programming cycle shows status");
    rd_chk(8'h30, 8'hA5, "R7 R9 data after completion");
    rd_chk(8'h31, 8'h3C, "R8 write during programming ignored");
    rd_chk(8'h3F, 8'h81, "R9 true bit 7 after completion");
    rd_chk(8'h32, 8'h00, "R9 unloaded byte untouched");
  endtask

  task automatic t_overwrite();
    wr(8'h50, 8'h11);
    wr(8'h50, 8'h92);
    wr(8'h51, 8'h05);
    rd_chk(8'h50, 8'h80, "R3 R4 new busy period restarts toggle");
    wait_cyc(LOAD_CYC + WRITE_CYC + 5);
    rd_chk(8'h50, 8'h92, "R10 later byte wins");
    rd_chk(8'h51, 8'h05, "R9 loaded byte stored");
    rd_chk(8'h52, 8'h00, "R9 unloaded byte untouched");
  endtask

  task automatic t_page_switch();
    wr(8'h60, 8'hC3);
    wr(8'h70, 8'h44);
    wait_cyc(WRITE_CYC - 1);
    rd_chk(8'h60, 8'h20, "R6 page change starts programming");
    rd_chk(8'h70, 8'h00, "R6 out-of-page byte discarded");
    rd_chk(8'h60, 8'hC3, "R6 in-page byte stored");
    wr(8'h61, 8'h7E);
    rd_chk(8'h61, 8'h80, "R7 new load accepted after completion");
    wait_cyc(LOAD_CYC + WRITE_CYC + 5);
    rd_chk(8'h61, 8'h7E, "R7 second page write stored");
    rd_chk(8'h60, 8'hC3, "R9 earlier byte of page kept");
  endtask

  initial begin
    wait_cyc(3);
    rst_ni = 1'b1;
    wait_cyc(2);
    t_reset();
    t_page_load();
    t_overwrite();
    t_page_switch();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule